// File: doc/BRIEF.md
# Write-only I2C register target

This block is an I2C target that only accepts write transfers. It sits behind two glitch-filtered bus inputs. Its 7-bit bus address is a fixed upper part with five strap pins filling the low bits. With the default base the address is binary 01 followed by the five straps. After a matching address with a write direction bit, the next byte loads a register pointer. Every byte after that is handed to a shared register file as a one-cycle write strobe carrying the pointer and the byte. The pointer then advances to the next register.

The acknowledge bit is driven through an open-drain enable: `sda_oe_o` high means the pad pulls the data line low. The block never stretches the clock and never returns data. It does not answer the general-call address or a read request.

The control is a single state machine with eight named states:
- `ST_IDLE`: waiting for a start.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR`: shifting in the pointer byte.
- `ST_PTR_ACK`: acknowledging the pointer byte.
- `ST_DATA`: shifting in a data byte.
- `ST_DATA_ACK`: acknowledging a data byte.
- `ST_SKIP`: a transfer addressed to someone else, or a read request, is ignored until the next start.

Transitions:
- A start takes any state to `ST_ADDR`, and a stop takes any state to `ST_IDLE`. A start wins over everything else.
- The eighth falling clock edge of a byte moves `ST_ADDR` to `ST_ADDR_ACK` if the address matches with a write bit, and to `ST_SKIP` otherwise.
- The same edge moves `ST_PTR` to `ST_PTR_ACK` and `ST_DATA` to `ST_DATA_ACK`.
- The ninth falling clock edge moves `ST_ADDR_ACK` to `ST_PTR`, and moves `ST_PTR_ACK` and `ST_DATA_ACK` to `ST_DATA`.

Top module: `i2c_wr_target`

## Requirements
- R1: Out of reset, `sda_oe_o` and `wr_en_o` are both 0.
- R2: The target answers the address whose bits 6..5 are 01 and whose bits 4..0 equal `strap_i`. The address is sent most significant bit first, followed by a direction bit of 0. The answer is an acknowledge: the data line is held low for the whole ninth clock pulse.
- R3: An address that differs from the strapped one gets no acknowledge. No byte that follows it, up to the next start, is acknowledged or written.
- R4: A matching address with direction bit 1 gets no acknowledge, and nothing is written until the next start.
- R5: `sda_oe_o` rises only after a falling clock edge that ends an eighth bit, and falls on the falling edge of the ninth clock (or on a start or stop). It never changes while the clock stays high.
- R6: The first byte after the address is the register pointer. Each later byte produces exactly one one-cycle `wr_en_o` pulse, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte.
- R7: The pointer advances by one after every data byte, and from 0x15 it wraps to 0x00.
- R8: A data byte sent while the pointer is above 0x15 is acknowledged but produces no write strobe.
- R9: A stop condition (data rising while the clock is high) returns the block to idle. Bytes clocked afterwards without a new start get no acknowledge and no write.
- R10: A repeated start (data falling while the clock is high, with no stop before it) returns the block to the address phase. A new pointer and new data are then accepted.
- R11: A pulse on either bus input that lasts only one system clock is ignored: it neither shifts a bit nor corrupts the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | STRAP_W | Strap pins forming the low address bits |
| sda_oe_o | output | 1 | High to pull the data line low (acknowledge) |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address for the strobe |
| wr_data_o | output | 8 | Register data for the strobe |

## Verification
The bench builds the target with its defaults: five strap bits, an address base of 0x20, a last register of 0x15 and two synchroniser stages. With a last register of 0x15, a stream of only three bytes starting at 0x14 crosses the wrap. A pointer of 0x20 already lies in the discarded range. The two-stage filter passes a bus edge after about four system clocks. The bench's bus quarter-period of twenty clocks therefore leaves room to check that the acknowledge is asserted before the ninth rising edge and released after the ninth falling edge. It can also inject one-clock glitches that must be rejected.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } wr_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         hist_q;
    logic         filt_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[MSB-1:0], line_i};
            end
        end
    endgenerate

    // the filtered level follows only after two equal synchronised samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 1'b1;
            filt_q <= 1'b1;
        end else begin
            hist_q <= sync_q[MSB];
            if (sync_q[MSB] == hist_q) filt_q <= hist_q;
        end
    end

    assign line_o = filt_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
        end
    end

    always_comb begin
        start_o    = scl_q && scl_f_i && sda_q && !sda_f_i;
        stop_o     = scl_q && scl_f_i && !sda_q && sda_f_i;
        scl_rise_o = !scl_q && scl_f_i;
        scl_fall_o = scl_q && !scl_f_i;
    end

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2c_wr_pkg::*;
#(
    parameter int                STRAP_W   = 5,
    parameter logic [6:0]        ADDR_BASE = 7'h20,
    parameter logic [BYTE_W-1:0] LAST_REG  = 8'h15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               sda_f_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [BYTE_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o
);

    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

    wr_state_e              state_q, state_d;
    logic [BYTE_W-1:0]      shift_q;
    logic [BIT_CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]      ptr_q;
    logic                   wr_en_q;
    logic [BYTE_W-1:0]      wr_addr_q;
    logic [BYTE_W-1:0]      wr_data_q;

    logic bus_event;
    logic byte_done;
    logic shifting;
    logic in_ack;
    logic addr_match;

    always_comb begin
        bus_event  = start_i || stop_i;
        shifting   = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_DATA);
        in_ack     = (state_q == ST_ADDR_ACK) || (state_q == ST_PTR_ACK) ||
                     (state_q == ST_DATA_ACK);
        byte_done  = shifting && scl_fall_i && (cnt_q == FULL_CNT) && !bus_event;
        addr_match = (shift_q[BYTE_W-1:1] == {ADDR_BASE[6:STRAP_W], strap_i}) &&
                     !shift_q[0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_SKIP:     state_d = ST_SKIP;
                ST_ADDR:     if (byte_done) state_d = addr_match ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall_i) state_d = ST_PTR;
                ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall_i) state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall_i) state_d = ST_DATA;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // byte shifter, bit counter and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else if (bus_event) begin
            cnt_q <= '0;
        end else begin
            if (shifting && scl_rise_i && (cnt_q != FULL_CNT)) begin
                shift_q <= {shift_q[BYTE_W-2:0], sda_f_i};
                cnt_q   <= cnt_q + 1'b1;
            end else if (in_ack && scl_fall_i) begin
                cnt_q <= '0;
            end
            if (byte_done && (state_q == ST_PTR)) begin
                ptr_q <= shift_q;
            end else if (byte_done && (state_q == ST_DATA)) begin
                ptr_q <= (ptr_q == LAST_REG) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // write strobe towards the register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= byte_done && (state_q == ST_DATA) && (ptr_q <= LAST_REG);
            if (byte_done && (state_q == ST_DATA)) begin
                wr_addr_q <= ptr_q;
                wr_data_q <= shift_q;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o  = in_ack;
        wr_en_o   = wr_en_q;
        wr_addr_o = wr_addr_q;
        wr_data_o = wr_data_q;
    end

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter int                STRAP_W     = 5,
    parameter logic [6:0]        ADDR_BASE   = 7'h20,
    parameter logic [BYTE_W-1:0] LAST_REG    = 8'h15,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [BYTE_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o
);

    localparam int N_LINES = 2;
    localparam int SCL_IDX = 1;
    localparam int SDA_IDX = 0;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic scl_f, sda_f;
    logic start_det, stop_det, scl_rise, scl_fall;

    assign raw_lines = {scl_i, sda_i};

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_filt
            i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (raw_lines[i]),
                .line_o (filt_lines[i])
            );
        end
    endgenerate

    assign scl_f = filt_lines[SCL_IDX];
    assign sda_f = filt_lines[SDA_IDX];

    i2c_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f_i    (scl_f),
        .sda_f_i    (sda_f),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    i2c_wr_fsm #(
        .STRAP_W   (STRAP_W),
        .ADDR_BASE (ADDR_BASE),
        .LAST_REG  (LAST_REG)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_i),
        .sda_f_i    (sda_f),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );

endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk #(
    parameter int         REG_AW   = 8,
    parameter logic [7:0] LAST_REG = 8'h15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe_o,
    input logic              wr_en_o,
    input logic [REG_AW-1:0] wr_addr_o,
    input logic              scl_f,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det
);

    assert_ack_begins_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall));

    assert_ack_ends_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

    assert_oe_steady_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    assert_strobe_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o <= REG_AW'(LAST_REG)));

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    assert_start_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

endmodule

bind i2c_wr_target i2c_wr_target_chk #(
    .REG_AW   (8),
    .LAST_REG (LAST_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .scl_f     (scl_f),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2c_wr_target_bench.sv
module i2c_wr_target_bench;

    localparam int Q = 20;
    localparam int LOG_N = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       g_scl = 1'b0;
    logic [4:0] strap = 5'h0B;
    logic       sda_oe, wr_en;
    logic [7:0] wr_addr, wr_data;
    logic       sda_bus, scl_bus;

    int n_tot = 0;
    int n_bad = 0;
    int log_n = 0;
    logic [7:0] log_a [LOG_N];
    logic [7:0] log_d [LOG_N];

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;
    assign scl_bus = m_scl | g_scl;

    i2c_wr_target u_i2c_wr_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .strap_i   (strap),
        .sda_oe_o  (sda_oe),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    always @(negedge clk) begin
        if (wr_en && log_n < LOG_N) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b1; wait_q(1);
    endtask

    // sends one byte; reports the acknowledge and its timing
    task automatic send_byte(input logic [7:0] b, input bit glitch,
                             output bit acked, output bit early, output bit freed);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_q(1);
            if (glitch && i == 7) begin
                @(negedge clk) g_scl = 1'b1;
                @(negedge clk) g_scl = 1'b0;
            end
            m_scl = 1'b1; wait_q(2);
            m_scl = 1'b0; wait_q(1);
        end
        m_sda = 1'b1; wait_q(1);
        early = sda_oe;
        m_scl = 1'b1; wait_q(1);
        acked = (sda_bus == 1'b0);
        wait_q(1);
        m_scl = 1'b0; wait_q(1);
        freed = !sda_oe;
    endtask

    function automatic logic [7:0] addr_byte(input logic [4:0] s, input bit rd);
        return {2'b01, s, rd};
    endfunction

    task automatic chk_log(input int idx, input logic [7:0] a, input logic [7:0] d, input string tag);
        chk(log_a[idx] == a, {tag, " addr"}, log_a[idx], a);
        chk(log_d[idx] == d, {tag, " data"}, log_d[idx], d);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
        chk(wr_en == 1'b0, "R1 strobe after reset", wr_en, 0);
    endtask

    task automatic t_basic();
        bit a, e, f;
        int base = log_n;
        strap = 5'h0B;
        do_start();
        send_byte(addr_byte(5'h0B, 1'b0), 1'b0, a, e, f);
        chk(a, "R2 address ack", a, 1);
        chk(e, "R5 ack before ninth rise", e, 1);
        chk(f, "R5 ack released after ninth fall", f, 1);
        send_byte(8'h03, 1'b0, a, e, f);
        chk(a, "R6 pointer ack", a, 1);
        send_byte(8'hA5, 1'b0, a, e, f);
        chk(a, "R6 data ack", a, 1);
        send_byte(8'h3C, 1'b0, a, e, f);
        do_stop();
        chk(log_n - base == 2, "R6 strobe count", log_n - base, 2);
        chk_log(base, 8'h03, 8'hA5, "R6 first write");
        chk_log(base + 1, 8'h04, 8'h3C, "R7 incremented write");
    endtask

    task automatic t_other_strap();
        bit a, e, f;
        int base = log_n;
        strap = 5'h1F;
        do_start();
        send_byte(addr_byte(5'h1F, 1'b0), 1'b0, a, e, f);
        chk(a, "R2 ack with strap 1F", a, 1);
        send_byte(8'h00, 1'b0, a, e, f);
        send_byte(8'h5E, 1'b0, a, e, f);
        do_stop();
        chk(log_n - base == 1, "R2 strobe count strap 1F", log_n - base, 1);
        chk_log(base, 8'h00, 8'h5E, "R2 write strap 1F");
        strap = 5'h0B;
    endtask

    task automatic t_wrap();
        bit a, e, f;
        int base = log_n;
        do_start();
        send_byte(addr_byte(strap, 1'b0), 1'b0, a, e, f);
        send_byte(8'h14, 1'b0, a, e, f);
        send_byte(8'h11, 1'b0, a, e, f);
        send_byte(8'h22, 1'b0, a, e, f);
        send_byte(8'h33, 1'b0, a, e, f);
        do_stop();
        chk(log_n - base == 3, "R7 wrap strobe count", log_n - base, 3);
        chk_log(base, 8'h14, 8'h11, "R7 before last");
        chk_log(base + 1, 8'h15, 8'h22, "R7 last register");
        chk_log(base + 2, 8'h00, 8'h33, "R7 wrapped to 00");
    endtask

    task automatic t_out_of_range();
        bit a, e, f;
        int base = log_n;
        do_start();
        send_byte(addr_byte(strap, 1'b0), 1'b0, a, e, f);
        send_byte(8'h20, 1'b0, a, e, f);
        send_byte(8'h77, 1'b0, a, e, f);
        chk(a, "R8 out-of-range byte acked", a, 1);
        do_stop();
        chk(log_n == base, "R8 no strobe above 15", log_n - base, 0);
    endtask

    task automatic t_wrong_addr();
        bit a, e, f;
        int base = log_n;
        do_start();
        send_byte(addr_byte(5'h0A, 1'b0), 1'b0, a, e, f);
        chk(!a, "R3 foreign address nack", a, 0);
        send_byte(8'h02, 1'b0, a, e, f);
        chk(!a, "R3 following byte nack", a, 0);
        send_byte(8'h99, 1'b0, a, e, f);
        do_stop();
        chk(log_n == base, "R3 no write", log_n - base, 0);
    endtask

    task automatic t_read_bit();
        bit a, e, f;
        int base = log_n;
        do_start();
        send_byte(addr_byte(strap, 1'b1), 1'b0, a, e, f);
        chk(!a, "R4 read request nack", a, 0);
        send_byte(8'h05, 1'b0, a, e, f);
        chk(!a, "R4 following byte nack", a, 0);
        do_stop();
        chk(log_n == base, "R4 no write", log_n - base, 0);
    endtask

    task automatic t_stop();
        bit a, e, f;
        int base;
        do_start();
        send_byte(addr_byte(strap, 1'b0), 1'b0, a, e, f);
        send_byte(8'h05, 1'b0, a, e, f);
        send_byte(8'h01, 1'b0, a, e, f);
        do_stop();
        base = log_n;
        m_scl = 1'b0; wait_q(1);
        send_byte(addr_byte(strap, 1'b0), 1'b0, a, e, f);
        chk(!a, "R9 no ack after stop", a, 0);
        send_byte(8'h44, 1'b0, a, e, f);
        chk(!a, "R9 second byte nack", a, 0);
        do_stop();
        chk(log_n == base, "R9 no write after stop", log_n - base, 0);
    endtask

    task automatic t_restart();
        bit a, e, f;
        int base = log_n;
        do_start();
        send_byte(addr_byte(strap, 1'b0), 1'b0, a, e, f);
        send_byte(8'h07, 1'b0, a, e, f);
        send_byte(8'h5A, 1'b0, a, e, f);
        do_start();
        send_byte(addr_byte(strap, 1'b0), 1'b0, a, e, f);
        chk(a, "R10 address ack after repeated start", a, 1);
        send_byte(8'h09, 1'b0, a, e, f);
        send_byte(8'h6B, 1'b0, a, e, f);
        do_stop();
        chk(log_n - base == 2, "R10 strobe count", log_n - base, 2);
        chk_log(base, 8'h07, 8'h5A, "R10 before restart");
        chk_log(base + 1, 8'h09, 8'h6B, "R10 new pointer");
    endtask

    task automatic t_glitch();
        bit a, e, f;
        int base = log_n;
        do_start();
        send_byte(addr_byte(strap, 1'b0), 1'b0, a, e, f);
        send_byte(8'h0C, 1'b0, a, e, f);
        send_byte(8'h96, 1'b1, a, e, f);
        chk(a, "R11 ack despite glitch", a, 1);
        do_stop();
        chk(log_n - base == 1, "R11 strobe count", log_n - base, 1);
        chk_log(base, 8'h0C, 8'h96, "R11 byte intact");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic();
        t_other_strap();
        t_wrap();
        t_out_of_range();
        t_wrong_addr();
        t_read_bit();
        t_stop();
        t_restart();
        t_glitch();
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tot++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule